// File: doc/BRIEF.md
# Transmit and Receive FIFO Start Threshold Controller

This block sits beside a pair of synchronous byte FIFOs in an Ethernet datapath. It decides when the transmit FIFO may start handing a frame to the line side, and when the receive FIFO may start passing a frame on to the DMA. Each direction has two modes. In store-and-forward mode a frame is released only once its last byte is in the FIFO. In cut-through mode a frame is released as soon as the fill level reaches a threshold. The requested threshold is rounded up to the next step of a fixed ladder, and the ladder differs between the two directions.

The block also manages the transmit side's housekeeping. It runs a flush sequence that clears itself, and it detects an underflow when the FIFO runs dry in the middle of a frame in cut-through mode, then discards the rest of that frame. It refuses checksum insertion unless the active transmit mode is store-and-forward. As an option it lets the next frame start before the status of the previous one has come back. A mode or threshold change is taken up only between frames.

The block moves no data itself. All pins are plain level or single-cycle pulse signals. The read side signals which byte is consumed and when a frame ends, so back-pressure is expressed by the consumer not pulsing a pop.

Top module: `tx_start_ctl`

## Requirements
- R1: With transmit store-and-forward active, `tx_start` is high only while at least one frame whose end was written (`tx_wr_eof`) has not yet been read out. The fill level and the requested threshold have no effect.
- R2: With cut-through active, the transmit threshold is the smallest of 32, 64, 128, 192 and 256 bytes that is not below `cfg_tx_thr_req`, and any request above 192 selects 256. `tx_start` rises when `tx_level` reaches that value.
- R3: With receive cut-through active, the receive threshold is the smallest of 32, 64, 96 and 128 bytes that is not below `cfg_rx_thr_req`, and any request above 96 selects 128. `rx_fwd_ok` rises when `rx_level` reaches it.
- R4: With `cfg_rx_sf` set, `rx_fwd_ok` is high only while a frame ended by `rx_wr_eof` is held, whatever the receive fill level.
- R5: A `flush_req` pulse makes `flush_busy` and `fifo_discard` read 1 from the next cycle onward, blocks `tx_start` and forgets the buffered frames. `flush_busy` clears by itself one cycle after `tx_level` is seen at 0.
- R6: `csum_refused` is 1 when `cfg_csum_ins` is set and the active transmit mode is cut-through, and 0 in store-and-forward mode.
- R7: When `cfg_early_second` is 0, after a frame's last byte is read (`tx_rd_eof`), `tx_start` stays low until `tx_status_done` is pulsed. When it is 1, the next frame may start at once.
- R8: In cut-through mode, if `tx_level` is 0 during a frame and no complete frame is held, then `underflow` is set and stays set until a `flush_req`. `fifo_discard` is held high and `tx_start` is held low until the rest of the frame ends with `tx_wr_eof`, and that end is not counted as a frame.
- R9: A change of `cfg_tx_sf` or of either threshold request takes effect only when no frame is being read. The mode of a frame that has already started is kept until its last byte.
- R10: After reset, `tx_start`, `rx_fwd_ok`, `flush_busy`, `fifo_discard` and `underflow` are all 0. The active transmit mode is store-and-forward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_tx_sf | input | 1 | Transmit store-and-forward enable |
| cfg_tx_thr_req | input | THR_W | Requested transmit threshold in bytes |
| cfg_rx_sf | input | 1 | Receive store-and-forward enable |
| cfg_rx_thr_req | input | THR_W | Requested receive threshold in bytes |
| cfg_csum_ins | input | 1 | Transmit checksum insertion wanted |
| cfg_early_second | input | 1 | Allow next frame before previous status returns |
| flush_req | input | 1 | Pulse: flush the transmit FIFO |
| tx_wr_eof | input | 1 | Pulse: last byte of a frame written to the TX FIFO |
| tx_level | input | LVL_W | TX FIFO fill level in bytes |
| tx_rd_pop | input | 1 | Byte taken from the TX FIFO |
| tx_rd_eof | input | 1 | Byte taken is the last of its frame |
| tx_status_done | input | 1 | Pulse: status of the last sent frame returned |
| rx_wr_eof | input | 1 | Pulse: last byte of a frame written to the RX FIFO |
| rx_level | input | LVL_W | RX FIFO fill level in bytes |
| rx_rd_pop | input | 1 | Byte taken from the RX FIFO |
| rx_rd_eof | input | 1 | Byte taken is the last of its frame |
| tx_start | output | 1 | Permission to start draining the next TX frame |
| rx_fwd_ok | output | 1 | Permission to start forwarding the next RX frame |
| flush_busy | output | 1 | Flush in progress, clears itself |
| fifo_discard | output | 1 | TX FIFO must drop its content and writes |
| underflow | output | 1 | Sticky transmit underflow flag |
| csum_refused | output | 1 | Checksum insertion refused in cut-through mode |

## Verification
Each ladder is exercised with requests just below a step, exactly on a step, just above a step and far beyond the top. The level is held one byte under the expected threshold and then on it, which separates a correct round-up from a round-down or an off-by-one compare. Store-and-forward is tried with a high fill level and no frame end, and then with the frame end, which shows that the level is ignored. Flush, underflow and the status wait are each driven through their whole sequence. A configuration change in the middle of a frame shows whether the mode is held until the frame's last byte.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

  // Round a requested transmit threshold up to the transmit ladder.
  function automatic int snap_tx(input int req);
    if (req <= 32)       return 32;
    else if (req <= 64)  return 64;
    else if (req <= 128) return 128;
    else if (req <= 192) return 192;
    else                 return 256;
  endfunction

  // Round a requested receive threshold up to the receive ladder.
  function automatic int snap_rx(input int req);
    if (req <= 32)      return 32;
    else if (req <= 64) return 64;
    else if (req <= 96) return 96;
    else                return 128;
  endfunction

endpackage

// File: rtl/tsc_thr_ladder.sv
module tsc_thr_ladder #(
  parameter bit FOR_TX = 1'b1,
  parameter int THR_W  = 9
) (
  input  logic [THR_W-1:0] req,
  output logic [THR_W-1:0] thr
);
  generate
    if (FOR_TX) begin : g_tx
      always_comb thr = THR_W'(tsc_pkg::snap_tx(int'(req)));
    end else begin : g_rx
      always_comb thr = THR_W'(tsc_pkg::snap_rx(int'(req)));
    end
  endgenerate
endmodule

// File: rtl/tsc_frame_gate.sv
module tsc_frame_gate #(
  parameter int LVL_W = 10,
  parameter int THR_W = 9,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             hold,
  input  logic             cfg_sf,
  input  logic [THR_W-1:0] cfg_thr,
  input  logic             wr_eof,
  input  logic             rd_pop,
  input  logic             rd_eof,
  input  logic [LVL_W-1:0] level,
  output logic             go,
  output logic             done,
  output logic             active,
  output logic             act_sf,
  output logic             frames_nz
);
  localparam int CMP_W = (LVL_W > THR_W) ? LVL_W : THR_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [THR_W-1:0] act_thr;
  logic [CNT_W-1:0] frames;
  logic             take;
  logic             lvl_ok;

  assign frames_nz = (frames != '0);
  assign lvl_ok    = CMP_W'(level) >= CMP_W'(act_thr);
  assign go        = !hold && !active && (frames_nz || (!act_sf && lvl_ok));
  assign take      = rd_pop && go;
  assign done      = rd_eof && (active || take);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frames  <= '0;
      active  <= 1'b0;
      act_sf  <= 1'b1;
      act_thr <= '1;
    end else begin
      if (clr)
        frames <= '0;
      else if (wr_eof && !done && frames != CNT_MAX)
        frames <= frames + 1'b1;
      else if (done && !wr_eof && frames_nz)
        frames <= frames - 1'b1;

      if (clr)
        active <= 1'b0;
      else if (take && !rd_eof)
        active <= 1'b1;
      else if (active && rd_eof)
        active <= 1'b0;

      // configuration is taken up only between frames
      if (!active && !take) begin
        act_sf  <= cfg_sf;
        act_thr <= cfg_thr;
      end
    end
  end
endmodule

// File: rtl/tx_start_ctl.sv
module tx_start_ctl #(
  parameter int LVL_W = 10,
  parameter int THR_W = 9,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_tx_sf,
  input  logic [THR_W-1:0] cfg_tx_thr_req,
  input  logic             cfg_rx_sf,
  input  logic [THR_W-1:0] cfg_rx_thr_req,
  input  logic             cfg_csum_ins,
  input  logic             cfg_early_second,
  input  logic             flush_req,
  input  logic             tx_wr_eof,
  input  logic [LVL_W-1:0] tx_level,
  input  logic             tx_rd_pop,
  input  logic             tx_rd_eof,
  input  logic             tx_status_done,
  input  logic             rx_wr_eof,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             rx_rd_pop,
  input  logic             rx_rd_eof,
  output logic             tx_start,
  output logic             rx_fwd_ok,
  output logic             flush_busy,
  output logic             fifo_discard,
  output logic             underflow,
  output logic             csum_refused
);
  logic [THR_W-1:0] tx_thr, rx_thr;
  logic tx_active, tx_act_sf, tx_frames_nz, tx_done;
  logic rx_active, rx_act_sf, rx_frames_nz, rx_done;
  logic drop, stat_wait, uf_ev, tx_hold, tx_clr;

  tsc_thr_ladder #(.FOR_TX(1'b1), .THR_W(THR_W)) u_tx_lad (.req(cfg_tx_thr_req), .thr(tx_thr));
  tsc_thr_ladder #(.FOR_TX(1'b0), .THR_W(THR_W)) u_rx_lad (.req(cfg_rx_thr_req), .thr(rx_thr));

  assign uf_ev   = tx_active && !tx_act_sf && (tx_level == '0) && !tx_frames_nz && !drop;
  assign tx_hold = flush_req || flush_busy || drop || (stat_wait && !cfg_early_second);
  assign tx_clr  = flush_req || uf_ev;

  tsc_frame_gate #(.LVL_W(LVL_W), .THR_W(THR_W), .CNT_W(CNT_W)) u_tx_gate (
    .clk(clk), .rst_n(rst_n), .clr(tx_clr), .hold(tx_hold),
    .cfg_sf(cfg_tx_sf), .cfg_thr(tx_thr),
    .wr_eof(tx_wr_eof && !drop), .rd_pop(tx_rd_pop), .rd_eof(tx_rd_eof),
    .level(tx_level), .go(tx_start), .done(tx_done), .active(tx_active),
    .act_sf(tx_act_sf), .frames_nz(tx_frames_nz)
  );

  tsc_frame_gate #(.LVL_W(LVL_W), .THR_W(THR_W), .CNT_W(CNT_W)) u_rx_gate (
    .clk(clk), .rst_n(rst_n), .clr(1'b0), .hold(1'b0),
    .cfg_sf(cfg_rx_sf), .cfg_thr(rx_thr),
    .wr_eof(rx_wr_eof), .rd_pop(rx_rd_pop), .rd_eof(rx_rd_eof),
    .level(rx_level), .go(rx_fwd_ok), .done(rx_done), .active(rx_active),
    .act_sf(rx_act_sf), .frames_nz(rx_frames_nz)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flush_busy <= 1'b0;
      drop       <= 1'b0;
      underflow  <= 1'b0;
      stat_wait  <= 1'b0;
    end else begin
      if (flush_req)
        flush_busy <= 1'b1;
      else if (flush_busy && tx_level == '0)
        flush_busy <= 1'b0;

      if (flush_req)
        drop <= 1'b0;
      else if (uf_ev)
        drop <= 1'b1;
      else if (tx_wr_eof)
        drop <= 1'b0;

      if (flush_req)
        underflow <= 1'b0;
      else if (uf_ev)
        underflow <= 1'b1;

      if (flush_req)
        stat_wait <= 1'b0;
      else if (tx_done)
        stat_wait <= 1'b1;
      else if (tx_status_done)
        stat_wait <= 1'b0;
    end
  end

  assign fifo_discard = flush_busy || drop;
  assign csum_refused = cfg_csum_ins && !tx_act_sf;
endmodule

// File: rtl/tsc_ctl_chk.sv
module tsc_ctl_chk #(
  parameter int LVL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush_req,
  input logic             tx_start,
  input logic             rx_fwd_ok,
  input logic             flush_busy,
  input logic             fifo_discard,
  input logic             underflow,
  input logic [LVL_W-1:0] tx_level,
  input logic             tx_active,
  input logic             tx_act_sf,
  input logic             tx_frames_nz,
  input logic             rx_active,
  input logic             rx_act_sf,
  input logic             rx_frames_nz,
  input logic             rx_done
);
  AST_SF_WHOLE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start && tx_act_sf |-> tx_frames_nz); // R1
  AST_RX_SF_WHOLE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fwd_ok && rx_act_sf |-> rx_frames_nz); // R4
  AST_RX_END_HAS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> rx_frames_nz); // R4
  AST_FLUSH_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_n)
    flush_busy |-> !tx_start); // R5
  AST_FLUSH_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    flush_busy && tx_level == '0 && !flush_req |=> !flush_busy); // R5
  AST_UNDERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    underflow && !flush_req |=> underflow); // R8
  AST_UNDERFLOW_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underflow) |-> fifo_discard && !tx_start); // R8
  AST_TX_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_active && $past(tx_active) |-> $stable(tx_act_sf)); // R9
  AST_RX_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_active && $past(rx_active) |-> $stable(rx_act_sf)); // R9
endmodule

bind tx_start_ctl tsc_ctl_chk #(.LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush_req(flush_req), .tx_start(tx_start),
  .rx_fwd_ok(rx_fwd_ok), .flush_busy(flush_busy), .fifo_discard(fifo_discard),
  .underflow(underflow), .tx_level(tx_level), .tx_active(tx_active),
  .tx_act_sf(tx_act_sf), .tx_frames_nz(tx_frames_nz), .rx_active(rx_active),
  .rx_act_sf(rx_act_sf), .rx_frames_nz(rx_frames_nz), .rx_done(rx_done)
);

// File: tb/tx_start_ctl_tb.sv
module tx_start_ctl_tb;
  localparam int LVL_W = 10;
  localparam int THR_W = 9;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_tx_sf, cfg_rx_sf, cfg_csum_ins, cfg_early_second, flush_req;
  logic [THR_W-1:0] cfg_tx_thr_req, cfg_rx_thr_req;
  logic tx_wr_eof, tx_rd_pop, tx_rd_eof, tx_status_done;
  logic rx_wr_eof, rx_rd_pop, rx_rd_eof;
  logic [LVL_W-1:0] tx_level, rx_level;
  logic tx_start, rx_fwd_ok, flush_busy, fifo_discard, underflow, csum_refused;

  int n_vec = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  tx_start_ctl #(.LVL_W(LVL_W), .THR_W(THR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_tx_sf(cfg_tx_sf), .cfg_tx_thr_req(cfg_tx_thr_req),
    .cfg_rx_sf(cfg_rx_sf), .cfg_rx_thr_req(cfg_rx_thr_req), .cfg_csum_ins(cfg_csum_ins),
    .cfg_early_second(cfg_early_second), .flush_req(flush_req), .tx_wr_eof(tx_wr_eof),
    .tx_level(tx_level), .tx_rd_pop(tx_rd_pop), .tx_rd_eof(tx_rd_eof),
    .tx_status_done(tx_status_done), .rx_wr_eof(rx_wr_eof), .rx_level(rx_level),
    .rx_rd_pop(rx_rd_pop), .rx_rd_eof(rx_rd_eof), .tx_start(tx_start),
    .rx_fwd_ok(rx_fwd_ok), .flush_busy(flush_busy), .fifo_discard(fifo_discard),
    .underflow(underflow), .csum_refused(csum_refused)
  );

  function automatic int tx_step(input int r);
    if (r <= 32) return 32;
    if (r <= 64) return 64;
    if (r <= 128) return 128;
    if (r <= 192) return 192;
    return 256;
  endfunction

  function automatic int rx_step(input int r);
    if (r <= 32) return 32;
    if (r <= 64) return 64;
    if (r <= 96) return 96;
    return 128;
  endfunction

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // inputs change just after a falling edge; checks sample 2 ns later
  task automatic do_reset(input logic tx_sf);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_tx_sf = tx_sf; cfg_rx_sf = 1'b0; cfg_csum_ins = 1'b0; cfg_early_second = 1'b0;
    cfg_tx_thr_req = '0; cfg_rx_thr_req = '0; flush_req = 1'b0;
    tx_wr_eof = 1'b0; tx_rd_pop = 1'b0; tx_rd_eof = 1'b0; tx_status_done = 1'b0;
    rx_wr_eof = 1'b0; rx_rd_pop = 1'b0; rx_rd_eof = 1'b0;
    tx_level = '0; rx_level = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_tx_eof();
    tx_wr_eof = 1'b1; @(negedge clk); tx_wr_eof = 1'b0;
  endtask

  task automatic read_tx_frame();
    tx_rd_pop = 1'b1; @(negedge clk);
    tx_rd_eof = 1'b1; @(negedge clk);
    tx_rd_pop = 1'b0; tx_rd_eof = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset(1'b1);
    cfg_csum_ins = 1'b1;
    #2;
    chk("R10", "tx_start", tx_start, 1'b0);
    chk("R10", "rx_fwd_ok", rx_fwd_ok, 1'b0);
    chk("R10", "flush_busy", flush_busy, 1'b0);
    chk("R10", "fifo_discard", fifo_discard, 1'b0);
    chk("R10", "underflow", underflow, 1'b0);
    chk("R10", "csum_refused (sf after reset)", csum_refused, 1'b0);
  endtask

  task automatic t_tx_sf();
    do_reset(1'b1);
    cfg_tx_thr_req = 9'd32;
    tx_level = 10'd300;
    @(negedge clk); #2;
    chk("R1", "start without frame end", tx_start, 1'b0);
    pulse_tx_eof(); #2;
    chk("R1", "start with complete frame", tx_start, 1'b1);
  endtask

  task automatic t_tx_ladder();
    int reqs[7] = '{1, 32, 33, 100, 129, 193, 511};
    do_reset(1'b0);
    for (int i = 0; i < 7; i++) begin
      cfg_tx_thr_req = THR_W'(reqs[i]);
      tx_level = LVL_W'(tx_step(reqs[i]) - 1);
      @(negedge clk); #2;
      chk("R2", $sformatf("req %0d below step", reqs[i]), tx_start, 1'b0);
      tx_level = LVL_W'(tx_step(reqs[i])); #2;
      chk("R2", $sformatf("req %0d on step", reqs[i]), tx_start, 1'b1);
    end
  endtask

  task automatic t_rx_ladder();
    int reqs[5] = '{10, 64, 65, 97, 400};
    do_reset(1'b1);
    for (int i = 0; i < 5; i++) begin
      cfg_rx_thr_req = THR_W'(reqs[i]);
      rx_level = LVL_W'(rx_step(reqs[i]) - 1);
      @(negedge clk); #2;
      chk("R3", $sformatf("req %0d below step", reqs[i]), rx_fwd_ok, 1'b0);
      rx_level = LVL_W'(rx_step(reqs[i])); #2;
      chk("R3", $sformatf("req %0d on step", reqs[i]), rx_fwd_ok, 1'b1);
    end
  endtask

  task automatic t_rx_sf();
    do_reset(1'b1);
    cfg_rx_sf = 1'b1; cfg_rx_thr_req = 9'd32; rx_level = 10'd200;
    @(negedge clk); #2;
    chk("R4", "forward without frame end", rx_fwd_ok, 1'b0);
    rx_wr_eof = 1'b1; @(negedge clk); rx_wr_eof = 1'b0; #2;
    chk("R4", "forward with complete frame", rx_fwd_ok, 1'b1);
  endtask

  task automatic t_flush();
    do_reset(1'b1);
    tx_level = 10'd100;
    pulse_tx_eof(); #2;
    chk("R5", "start before flush", tx_start, 1'b1);
    flush_req = 1'b1; @(negedge clk); flush_req = 1'b0; #2;
    chk("R5", "flush_busy set", flush_busy, 1'b1);
    chk("R5", "discard during flush", fifo_discard, 1'b1);
    chk("R5", "start blocked", tx_start, 1'b0);
    repeat (3) @(negedge clk); #2;
    chk("R5", "busy while not empty", flush_busy, 1'b1);
    tx_level = '0;
    @(negedge clk); #2;
    chk("R5", "busy cleared when empty", flush_busy, 1'b0);
    chk("R5", "frames forgotten", tx_start, 1'b0);
  endtask

  task automatic t_csum();
    do_reset(1'b1);
    cfg_csum_ins = 1'b1; #2;
    chk("R6", "accepted in sf", csum_refused, 1'b0);
    cfg_tx_sf = 1'b0;
    @(negedge clk); #2;
    chk("R6", "refused in cut-through", csum_refused, 1'b1);
  endtask

  task automatic t_status_wait();
    do_reset(1'b1);
    pulse_tx_eof();
    pulse_tx_eof();
    read_tx_frame(); #2;
    chk("R7", "held until status", tx_start, 1'b0);
    tx_status_done = 1'b1; @(negedge clk); tx_status_done = 1'b0; #2;
    chk("R7", "released by status", tx_start, 1'b1);
    cfg_early_second = 1'b1;
    pulse_tx_eof();
    read_tx_frame(); #2;
    chk("R7", "early next frame", tx_start, 1'b1);
  endtask

  task automatic t_underflow();
    do_reset(1'b0);
    cfg_tx_thr_req = 9'd64; tx_level = 10'd64;
    @(negedge clk); #2;
    chk("R2", "start at 64", tx_start, 1'b1);
    tx_rd_pop = 1'b1; @(negedge clk); tx_rd_pop = 1'b0;
    tx_level = '0;
    @(negedge clk); tx_level = 10'd70; #2;
    chk("R8", "underflow set", underflow, 1'b1);
    chk("R8", "discard rest of frame", fifo_discard, 1'b1);
    chk("R8", "start held", tx_start, 1'b0);
    pulse_tx_eof(); #2;
    chk("R8", "discard ends at frame end", fifo_discard, 1'b0);
    tx_level = '0; #2;
    chk("R8", "dropped end not counted", tx_start, 1'b0);
    repeat (2) @(negedge clk); #2;
    chk("R8", "underflow sticky", underflow, 1'b1);
    flush_req = 1'b1; @(negedge clk); flush_req = 1'b0; #2;
    chk("R8", "flush clears underflow", underflow, 1'b0);
  endtask

  task automatic t_mode_boundary();
    do_reset(1'b0);
    cfg_csum_ins = 1'b1; cfg_tx_thr_req = 9'd32; tx_level = 10'd40;
    @(negedge clk); #2;
    chk("R9", "start in cut-through", tx_start, 1'b1);
    tx_rd_pop = 1'b1; @(negedge clk); tx_rd_pop = 1'b0;
    cfg_tx_sf = 1'b1;
    repeat (2) @(negedge clk); #2;
    chk("R9", "mode kept mid-frame", csum_refused, 1'b1);
    pulse_tx_eof();
    tx_rd_pop = 1'b1; tx_rd_eof = 1'b1; @(negedge clk);
    tx_rd_pop = 1'b0; tx_rd_eof = 1'b0;
    @(negedge clk); #2;
    chk("R9", "new mode after frame end", csum_refused, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0;
    fork
      begin
        t_reset_state();
        t_tx_sf();
        t_tx_ladder();
        t_rx_ladder();
        t_rx_sf();
        t_flush();
        t_csum();
        t_status_wait();
        t_underflow();
        t_mode_boundary();
      end
      begin
        #2_000_000;
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule